// File: doc/BRIEF.md
# Float Sign, Compare and Min/Max Unit

This unit carries out the non-arithmetic operations on single-precision IEEE binary32 values: sign manipulation, ordered comparison, minimum and maximum, and classification. Two operands and a 4-bit operation code enter together with a valid strobe. One registered 32-bit result and its valid flag appear on the next clock edge.

The sign operations and min/max return a float. The comparisons and classify return an integer. Sign operations keep a NaN payload unchanged. Min and max replace any NaN with a single canonical quiet NaN.

Comparisons follow the unordered rules: any NaN operand makes the pair unordered. Zeros of either sign compare equal. Min and max use a stricter order in which negative zero sits below positive zero.

Top module: `fp_signcmp_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_data` are cleared to 0 on that edge. Reset takes priority over `in_valid`.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. The result of an accepted operation appears on `out_data` one cycle after it is presented.
- R3: When `in_valid` is low, `out_data` keeps its previous value, whatever the other inputs do.
- R4: Opcode 0 (negate) returns `in_a` with bit 31 inverted. Bits 30..0 are copied unchanged, NaN payloads included.
- R5: Bits 30..0 of `in_a` are kept unchanged and only bit 31 is set, as follows:
  - opcode 1 sets bit 31 to bit 31 of `in_b`;
  - opcode 2 sets it to the inverse of that bit;
  - opcode 3 sets it to the XOR of both sign bits.
- R6: Opcodes 4 (equal), 5 (not-equal), 6 (less-or-equal) and 7 (less-than) return 0 or 1 in bit 0, with bits 31..1 zero. They compare `in_a` against `in_b` by numeric value.
- R7: If either operand is a NaN (exponent all ones, fraction nonzero), equal, less-than and less-or-equal return 0 and not-equal returns 1.
- R8: The comparisons treat -0 (0x80000000) and +0 (0x00000000) as equal: equal and less-or-equal return 1, and less-than returns 0.
- R9: Opcode 8 (min) and opcode 9 (max) return the smaller or larger operand. In this order -0 ranks below +0, so min(-0,+0) is 0x80000000 and max(-0,+0) is 0x00000000 in either operand order.
- R10: If either operand of min or max is a NaN, the result is 0x7FC00000.
- R11: Opcode 10 (classify) returns a one-hot mask of `in_a` in bits 9..0, with bits 31..10 zero. Bit 0 is -inf, 1 -normal, 2 -subnormal, 3 -0, 4 +0, 5 +subnormal, 6 +normal, 7 +inf, 8 signalling NaN (fraction bit 22 clear) and 9 quiet NaN (fraction bit 22 set).
- R12: Opcodes 11 through 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand (binary32) |
| in_b | input | 32 | Second operand (binary32) |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 32 | Registered float or integer result |

## Verification
Two things meet in the same cycle when operations stream back to back: the register presents the result of operation N while operation N+1 is being accepted. The table of vectors is driven with no gaps, so every cycle performs one capture and one presentation. Each result is judged one cycle after its vector against the value worked out from the requirements. The bench then drops the strobe and, separately, raises reset in the same cycle as a valid operand. It checks that holding and reset win over capture exactly as R3 and R1 state.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [3:0] {
    OP_NEG    = 4'd0,
    OP_CPYSGN = 4'd1,
    OP_NCPSGN = 4'd2,
    OP_XORSGN = 4'd3,
    OP_EQ     = 4'd4,
    OP_NE     = 4'd5,
    OP_LE     = 4'd6,
    OP_LT     = 4'd7,
    OP_MIN    = 4'd8,
    OP_MAX    = 4'd9,
    OP_CLASS  = 4'd10
  } fsc_op_e;

  localparam int CLS_W = 10;

  typedef enum int {
    CLS_NINF  = 0,
    CLS_NNORM = 1,
    CLS_NSUB  = 2,
    CLS_NZERO = 3,
    CLS_PZERO = 4,
    CLS_PSUB  = 5,
    CLS_PNORM = 6,
    CLS_PINF  = 7,
    CLS_SNAN  = 8,
    CLS_QNAN  = 9
  } fsc_cls_bit_e;
endpackage

// File: rtl/fsc_sign.sv
module fsc_sign #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic                 b_sign,
  input  logic [1:0]           mode,
  output logic [EXP_W+MAN_W:0] y
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic new_sign;

  always_comb begin
    unique case (mode)
      2'd0:    new_sign = ~a[W-1];
      2'd1:    new_sign = b_sign;
      2'd2:    new_sign = ~b_sign;
      default: new_sign = a[W-1] ^ b_sign;
    endcase
    y = {new_sign, a[W-2:0]};
  end
endmodule

// File: rtl/fsc_order.sv
module fsc_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic                 eq,
  output logic                 ne,
  output logic                 lt,
  output logic                 le,
  output logic [EXP_W+MAN_W:0] vmin,
  output logic [EXP_W+MAN_W:0] vmax
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic         sa, sb, nan_a, nan_b, unord, both_zero;
  logic         mag_lt, mag_gt, ord_lt, tot_lt;
  logic [W-2:0] mag_a, mag_b;

  always_comb begin
    sa        = a[W-1];
    sb        = b[W-1];
    mag_a     = a[W-2:0];
    mag_b     = b[W-2:0];
    nan_a     = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    nan_b     = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    unord     = nan_a | nan_b;
    both_zero = (mag_a == '0) && (mag_b == '0);
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;

    // Numeric order: signed zeros are equal
    if (sa != sb) ord_lt = sa & ~both_zero;
    else          ord_lt = sa ? mag_gt : mag_lt;

    // Total order used by min/max: -0 below +0
    if (sa != sb) tot_lt = sa;
    else          tot_lt = sa ? mag_gt : mag_lt;

    eq   = ~unord & ((a == b) | both_zero);
    ne   = ~eq;
    lt   = ~unord & ord_lt;
    le   = lt | eq;
    vmin = unord ? CANON_NAN : (tot_lt ? a : b);
    vmax = unord ? CANON_NAN : (tot_lt ? b : a);
  end
endmodule

// File: rtl/fsc_class.sv
module fsc_class
  import fsc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  output logic [CLS_W-1:0]     mask
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic s, exp_ones, exp_zero, man_zero;

  always_comb begin
    s        = a[W-1];
    exp_ones = &a[W-2:MAN_W];
    exp_zero = ~|a[W-2:MAN_W];
    man_zero = ~|a[MAN_W-1:0];
    mask     = '0;
    if (exp_ones) begin
      if (man_zero)          mask[s ? CLS_NINF : CLS_PINF] = 1'b1;
      else if (a[MAN_W-1])   mask[CLS_QNAN]                = 1'b1;
      else                   mask[CLS_SNAN]                = 1'b1;
    end else if (exp_zero) begin
      if (man_zero)          mask[s ? CLS_NZERO : CLS_PZERO] = 1'b1;
      else                   mask[s ? CLS_NSUB  : CLS_PSUB]  = 1'b1;
    end else begin
      mask[s ? CLS_NNORM : CLS_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_signcmp_unit.sv
module fp_signcmp_unit
  import fsc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0]           in_op,
  input  logic [EXP_W+MAN_W:0] in_a,
  input  logic [EXP_W+MAN_W:0] in_b,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] out_data
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-1:0]     sign_y, min_y, max_y, nxt;
  logic [CLS_W-1:0] cls_y;
  logic             c_eq, c_ne, c_lt, c_le;

  fsc_sign #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sign (
    .a(in_a), .b_sign(in_b[W-1]), .mode(in_op[1:0]), .y(sign_y)
  );

  fsc_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a(in_a), .b(in_b), .eq(c_eq), .ne(c_ne), .lt(c_lt), .le(c_le),
    .vmin(min_y), .vmax(max_y)
  );

  fsc_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
    .a(in_a), .mask(cls_y)
  );

  always_comb begin
    nxt = '0;
    case (in_op)
      OP_NEG, OP_CPYSGN, OP_NCPSGN, OP_XORSGN: nxt = sign_y;
      OP_EQ:    nxt = {{(W-1){1'b0}}, c_eq};
      OP_NE:    nxt = {{(W-1){1'b0}}, c_ne};
      OP_LE:    nxt = {{(W-1){1'b0}}, c_le};
      OP_LT:    nxt = {{(W-1){1'b0}}, c_lt};
      OP_MIN:   nxt = min_y;
      OP_MAX:   nxt = max_y;
      OP_CLASS: nxt = {{(W-CLS_W){1'b0}}, cls_y};
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [3:0]           in_op,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_data
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, b_nan, is_cmp;
  assign a_nan  = (&in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]);
  assign b_nan  = (&in_b[W-2:MAN_W]) && (|in_b[MAN_W-1:0]);
  assign is_cmp = (in_op == OP_EQ) || (in_op == OP_NE) ||
                  (in_op == OP_LE) || (in_op == OP_LT);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  assert_negate_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_NEG) |=>
      out_data == {~$past(in_a[W-1]), $past(in_a[W-2:0])});

  assert_cmp_bool_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> out_data[W-1:1] == '0);

  assert_minmax_nan_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_MIN || in_op == OP_MAX) && (a_nan || b_nan))
      |=> out_data == CANON_NAN);

  assert_class_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLASS) |=>
      ($countones(out_data) == 1 && out_data[W-1:CLS_W] == '0));

  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > OP_CLASS) |=> out_data == '0);
endmodule

bind fp_signcmp_unit fsc_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_fp_signcmp_unit.sv
`timescale 1ns/1ps
module sim_fp_signcmp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_data;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fp_signcmp_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  // {op, a, b, expected, requirement number}
  localparam int NV = 39;
  localparam logic [107:0] VEC [NV] = '{
    {4'd0,  32'h3F800000, 32'h00000000, 32'hBF800000, 8'd4},  // R4
    {4'd0,  32'h7FC12345, 32'h00000000, 32'hFFC12345, 8'd4},  // R4 payload kept
    {4'd1,  32'h3F800000, 32'hC0000000, 32'hBF800000, 8'd5},  // R5
    {4'd1,  32'hBF800000, 32'h40000000, 32'h3F800000, 8'd5},  // R5
    {4'd2,  32'h3F800000, 32'h40000000, 32'hBF800000, 8'd5},  // R5
    {4'd2,  32'h7F800001, 32'hFF800000, 32'h7F800001, 8'd5},  // R5 sNaN kept
    {4'd3,  32'hBF800000, 32'hC0000000, 32'h3F800000, 8'd5},  // R5
    {4'd3,  32'hBF800000, 32'h40000000, 32'hBF800000, 8'd5},  // R5
    {4'd4,  32'h3F800000, 32'h3F800000, 32'h00000001, 8'd6},  // R6
    {4'd7,  32'hC0000000, 32'hBF800000, 32'h00000001, 8'd6},  // R6
    {4'd7,  32'hBF800000, 32'hC0000000, 32'h00000000, 8'd6},  // R6
    {4'd6,  32'h40000000, 32'h3F800000, 32'h00000000, 8'd6},  // R6
    {4'd5,  32'h3F800000, 32'h40000000, 32'h00000001, 8'd6},  // R6
    {4'd4,  32'h00000000, 32'h80000000, 32'h00000001, 8'd8},  // R8
    {4'd7,  32'h80000000, 32'h00000000, 32'h00000000, 8'd8},  // R8
    {4'd6,  32'h80000000, 32'h00000000, 32'h00000001, 8'd8},  // R8
    {4'd4,  32'h7FC00000, 32'h7FC00000, 32'h00000000, 8'd7},  // R7
    {4'd5,  32'h7FC00000, 32'h7FC00000, 32'h00000001, 8'd7},  // R7
    {4'd6,  32'h7F800001, 32'h7F800000, 32'h00000000, 8'd7},  // R7
    {4'd7,  32'hFF800000, 32'h7FC12345, 32'h00000000, 8'd7},  // R7
    {4'd8,  32'h80000000, 32'h00000000, 32'h80000000, 8'd9},  // R9
    {4'd9,  32'h80000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
    {4'd8,  32'h00000000, 32'h80000000, 32'h80000000, 8'd9},  // R9
    {4'd9,  32'hC0000000, 32'hBF800000, 32'hBF800000, 8'd9},  // R9
    {4'd8,  32'hFF800000, 32'h3F800000, 32'hFF800000, 8'd9},  // R9
    {4'd8,  32'h7FC12345, 32'h3F800000, 32'h7FC00000, 8'd10}, // R10
    {4'd9,  32'h3F800000, 32'hFF800001, 32'h7FC00000, 8'd10}, // R10
    {4'd10, 32'hFF800000, 32'h0,        32'h00000001, 8'd11}, // R11
    {4'd10, 32'hBF800000, 32'h0,        32'h00000002, 8'd11}, // R11
    {4'd10, 32'h80000001, 32'h0,        32'h00000004, 8'd11}, // R11
    {4'd10, 32'h80000000, 32'h0,        32'h00000008, 8'd11}, // R11
    {4'd10, 32'h00000000, 32'h0,        32'h00000010, 8'd11}, // R11
    {4'd10, 32'h00000001, 32'h0,        32'h00000020, 8'd11}, // R11
    {4'd10, 32'h3F800000, 32'h0,        32'h00000040, 8'd11}, // R11
    {4'd10, 32'h7F800000, 32'h0,        32'h00000080, 8'd11}, // R11
    {4'd10, 32'h7F800001, 32'h0,        32'h00000100, 8'd11}, // R11
    {4'd10, 32'h7FC00000, 32'h0,        32'h00000200, 8'd11}, // R11
    {4'd11, 32'h3F800000, 32'h3F800000, 32'h00000000, 8'd12}, // R12
    {4'd15, 32'hFFFFFFFF, 32'h3F800000, 32'h00000000, 8'd12}  // R12
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] last_exp;
    last_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && out_data == 32'd0, "R1 reset state",
          {31'd0, out_valid} | out_data, 32'd0);
    rst = 1'b0;

    // Back-to-back stream of the vector table (R2 on every result)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(out_valid == 1'b1, "R2 valid after one cycle",
              {31'd0, out_valid}, 32'd1);
        check(out_data == VEC[i-1][39:8],
              $sformatf("R%0d vector %0d", VEC[i-1][7:0], i-1),
              out_data, VEC[i-1][39:8]);
        last_exp = VEC[i-1][39:8];
      end
      if (i < NV) begin
        in_valid = 1'b1;
        in_op    = VEC[i][107:104];
        in_a     = VEC[i][103:72];
        in_b     = VEC[i][71:40];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R2/R3: idle cycle drops valid and holds data
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid drops", {31'd0, out_valid}, 32'd0);
    check(out_data == last_exp, "R3 hold when idle", out_data, last_exp);
    in_op = 4'd0; in_a = 32'h12345678; in_b = 32'h87654321;
    @(negedge clk);
    check(out_data == last_exp, "R3 inputs ignored when idle", out_data, last_exp);

    // R3 then R1: accept a value, then reset alongside a valid input
    in_valid = 1'b1; in_op = 4'd1; in_a = 32'h40000000; in_b = 32'h80000000;
    @(negedge clk);
    check(out_data == 32'hC0000000, "R5 copysign before reset", out_data, 32'hC0000000);
    rst = 1'b1; in_op = 4'd0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 32'd0, "R1 reset beats valid",
          out_data, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 32'd0, "R3 idle after reset",
          out_data, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule